// File: doc/BRIEF.md
# Built-in Self-Test PN Receive Checker

This block sits on one receive lane, after the 8B/10B decoder, during a built-in self-test run. Each clock brings one decoded code group: a data byte, a flag marking it as a control (K) character, a comma indication and a flag saying that the lane has byte/word alignment. The checker runs its own pseudo-noise generator, locks it onto the incoming test pattern, and then compares every later data code group with the byte it predicts.

For each code group it reports a status on three wires (error, data-valid, comma). These separate five conditions: still searching for alignment, aligned but not yet locked, running with a clean byte, running with a comma, and running with a PN mismatch. A saturating counter records how many mismatches were found while locked. Its value can be read at any time.

Idle ordered sets may be mixed into the pattern. K characters are never compared and never move the generator. The data byte that follows a K28.5 comma, which is the second half of an idle set, is skipped as well.

Top module: `bist_pn_checker`

## Requirements
- R1: While `rxAligned` is low, the status is error=0, data-valid=0, comma=0.
- R2: While aligned but not locked, the status is error=1, data-valid=0, comma=0. This includes the code group that completes the lock.
- R3: The pattern is PRBS7 with polynomial x^7+x^6+1. Each new bit is state[6] XOR state[5], and the state shifts left with the new bit entering at bit 0. Eight new bits form one byte, with the first bit in bit 7. The last 7 bits of a byte are therefore byte[6:0], which is the state for the next byte.
- R4: Locking works as follows. The first compared data byte after alignment loads the generator from its bits [6:0]. The next 8 consecutive compared data bytes must then match. A mismatch during this phase reloads the generator from the mismatching byte and restarts the run of 8.
- R5: While locked, a data byte that matches gives the status 0,1,0. A code group with `rxComma` high gives 0,1,1.
- R6: While locked, a data byte that does not match gives the status 1,1,0. Lock is kept, and the generator still advances to the byte it predicted.
- R7: K code groups are neither compared nor allowed to advance the generator. The data byte right after a K28.5 (K flag with byte 0xBC) is also skipped. A data byte after any other K character is compared.
- R8: Loss of alignment drops the lock, so a fresh load and run of 8 are needed again.
- R9: `mismatchCnt` is 16 bits wide. It rises by one for each mismatch found while locked, saturates at 0xFFFF, is cleared by reset, and otherwise holds its value.
- R10: The status and counter for a code group appear at the outputs one clock after that code group is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, one code group per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Decoded byte |
| rxIsK | input | 1 | Code group is a control character |
| rxComma | input | 1 | Code group is a comma |
| rxAligned | input | 1 | Byte/word alignment present |
| statErr | output | 1 | Status: error wire |
| statDv | output | 1 | Status: data-valid wire |
| statComma | output | 1 | Status: comma wire |
| mismatchCnt | output | 16 | Saturating count of locked mismatches |

## Verification
The bench sends a mismatch on the last byte before the lock would be reached. A design that counts mismatches toward the run of 8, or that fails to reload, locks too early or onto a bad phase, and later clean bytes then show up as errors.

Idle sets are placed both inside the lock run and after lock. The byte that follows K28.5 is chosen to be the complement of the predicted byte. A design that compares it, or that lets idles move the generator, therefore reports false mismatches.

A data byte after a non-comma K character must still be compared. After a dropout in alignment, the bench expects the unlocked status again. Finally, more than 65,535 mismatches are sent to catch a counter that wraps to zero.

// File: rtl/bist_pn_pkg.sv
package bist_pn_pkg;

  // strobes from the lock controller to the PN datapath
  typedef struct packed {
    logic loadSeed;  // load generator from the current byte
    logic advance;   // step generator by one byte
    logic countErr;  // count a locked mismatch
  } pnStrobe_t;

  typedef enum logic [1:0] {
    LK_SEED   = 2'd0,
    LK_VERIFY = 2'd1,
    LK_LOCKED = 2'd2
  } lockState_t;

endpackage

// File: rtl/bist_pn_datapath.sv
module bist_pn_datapath
  import bist_pn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PN_LEN = 7,
  parameter int TAP_HI = 7,
  parameter int TAP_LO = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  pnStrobe_t         strobe,
  output logic              pnMatch,
  output logic [CNT_W-1:0]  mismatchCnt
);

  localparam logic [PN_LEN-1:0] STATE_INIT = '1;

  logic [PN_LEN-1:0] pnState;
  logic [PN_LEN-1:0] pnNext;
  logic [DATA_W-1:0] expByte;

  // unroll DATA_W serial steps of the generator
  always_comb begin : gen_step
    logic [PN_LEN-1:0] st;
    logic              nb;
    st      = pnState;
    expByte = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      nb         = st[TAP_HI-1] ^ st[TAP_LO-1];
      expByte[i] = nb;
      st         = {st[PN_LEN-2:0], nb};
    end
    pnNext = st;
  end

  assign pnMatch = (expByte == dataIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pnState <= STATE_INIT;
    end else if (strobe.loadSeed) begin
      pnState <= dataIn[PN_LEN-1:0];
    end else if (strobe.advance) begin
      pnState <= pnNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mismatchCnt <= '0;
    end else if (strobe.countErr && (mismatchCnt != '1)) begin
      mismatchCnt <= mismatchCnt + 1'b1;
    end
  end

endmodule

// File: rtl/bist_pn_control.sv
module bist_pn_control
  import bist_pn_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              LOCK_RUN   = 8,
  parameter logic [DATA_W-1:0] COMMA_CODE = 8'hBC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              kFlag,
  input  logic              commaIn,
  input  logic              alignOk,
  input  logic              pnMatch,
  output pnStrobe_t         strobe,
  output logic              statErr,
  output logic              statDv,
  output logic              statComma
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  lockState_t       lockSt, lockNext;
  logic [RUN_W-1:0] runCnt, runNext;
  logic             skipNext;
  logic             isData;
  logic             errN, dvN, cmN;

  assign isData = alignOk && !kFlag && !skipNext;

  always_comb begin
    strobe   = '0;
    lockNext = lockSt;
    runNext  = runCnt;
    if (!alignOk) begin
      lockNext = LK_SEED;
      runNext  = '0;
    end else if (isData) begin
      case (lockSt)
        LK_SEED: begin
          strobe.loadSeed = 1'b1;
          lockNext        = LK_VERIFY;
          runNext         = '0;
        end
        LK_VERIFY: begin
          if (pnMatch) begin
            strobe.advance = 1'b1;
            if (runCnt == RUN_LAST) begin
              lockNext = LK_LOCKED;
              runNext  = '0;
            end else begin
              runNext = runCnt + 1'b1;
            end
          end else begin
            strobe.loadSeed = 1'b1;
            runNext         = '0;
          end
        end
        LK_LOCKED: begin
          strobe.advance  = 1'b1;
          strobe.countErr = !pnMatch;
        end
        default: lockNext = LK_SEED;
      endcase
    end
  end

  // status for the current code group, from the lock state before it
  always_comb begin
    errN = 1'b0;
    dvN  = 1'b0;
    cmN  = 1'b0;
    if (!alignOk) begin
      errN = 1'b0;
    end else if (lockSt != LK_LOCKED) begin
      errN = 1'b1;
    end else if (commaIn) begin
      dvN = 1'b1;
      cmN = 1'b1;
    end else begin
      dvN  = 1'b1;
      errN = isData && !pnMatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockSt    <= LK_SEED;
      runCnt    <= '0;
      skipNext  <= 1'b0;
      statErr   <= 1'b0;
      statDv    <= 1'b0;
      statComma <= 1'b0;
    end else begin
      lockSt    <= lockNext;
      runCnt    <= runNext;
      skipNext  <= alignOk && kFlag && (dataIn == COMMA_CODE);
      statErr   <= errN;
      statDv    <= dvN;
      statComma <= cmN;
    end
  end

endmodule

// File: rtl/bist_pn_checker.sv
module bist_pn_checker
  import bist_pn_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LOCK_RUN = 8,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxIsK,
  input  logic              rxComma,
  input  logic              rxAligned,
  output logic              statErr,
  output logic              statDv,
  output logic              statComma,
  output logic [CNT_W-1:0]  mismatchCnt
);

  pnStrobe_t strobe;
  logic      pnMatch;

  bist_pn_control #(
    .DATA_W    (DATA_W),
    .LOCK_RUN  (LOCK_RUN),
    .COMMA_CODE(DATA_W'(8'hBC))
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (rxData),
    .kFlag    (rxIsK),
    .commaIn  (rxComma),
    .alignOk  (rxAligned),
    .pnMatch  (pnMatch),
    .strobe   (strobe),
    .statErr  (statErr),
    .statDv   (statDv),
    .statComma(statComma)
  );

  bist_pn_datapath #(
    .DATA_W(DATA_W),
    .PN_LEN(7),
    .TAP_HI(7),
    .TAP_LO(6),
    .CNT_W (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (rxData),
    .strobe     (strobe),
    .pnMatch    (pnMatch),
    .mismatchCnt(mismatchCnt)
  );

endmodule

// File: rtl/bist_pn_checker_sva.sv
module bist_pn_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxAligned,
  input logic             statErr,
  input logic             statDv,
  input logic             statComma,
  input logic [CNT_W-1:0] mismatchCnt
);

  // R1: no alignment gives an all-low status one cycle later
  a_r1_noalign_status: assert property (@(posedge clk) disable iff (!rstN)
    !rxAligned |=> (!statErr && !statDv && !statComma));

  // R5: comma status only appears while running clean
  a_r5_comma_running: assert property (@(posedge clk) disable iff (!rstN)
    statComma |-> (statDv && !statErr));

  // R8: data-valid needs alignment on the previous code group
  a_r8_dv_needs_align: assert property (@(posedge clk) disable iff (!rstN)
    statDv |-> $past(rxAligned));

  // R9: a reported mismatch raises the counter unless saturated
  a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (statErr && statDv && ($past(mismatchCnt) != '1))
      |-> (mismatchCnt == CNT_W'($past(mismatchCnt) + 1'b1)));

  // R9: without a reported mismatch the counter holds
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(statErr && statDv) |-> $stable(mismatchCnt));

endmodule

bind bist_pn_checker bist_pn_checker_sva #(.CNT_W(CNT_W)) sva_i (
  .clk        (clk),
  .rstN       (rstN),
  .rxAligned  (rxAligned),
  .statErr    (statErr),
  .statDv     (statDv),
  .statComma  (statComma),
  .mismatchCnt(mismatchCnt)
);

// File: tb/bist_pn_checker_tb_top.sv
module bist_pn_checker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxIsK = 1'b0;
  logic        rxComma = 1'b0;
  logic        rxAligned = 1'b0;
  logic        statErr, statDv, statComma;
  logic [15:0] mismatchCnt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [6:0] bSt = '0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycles <= cycles + 1;

  bist_pn_checker dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxIsK(rxIsK),
    .rxComma(rxComma), .rxAligned(rxAligned), .statErr(statErr),
    .statDv(statDv), .statComma(statComma), .mismatchCnt(mismatchCnt)
  );

  // kinds of code group
  localparam logic [2:0] KN = 3'd0;  // not aligned
  localparam logic [2:0] KS = 3'd1;  // seed byte
  localparam logic [2:0] KG = 3'd2;  // good PN byte
  localparam logic [2:0] KV = 3'd3;  // bad byte while verifying (reseeds)
  localparam logic [2:0] KL = 3'd4;  // bad byte while locked
  localparam logic [2:0] KI = 3'd5;  // K28.5 idle
  localparam logic [2:0] KD = 3'd6;  // data after K28.5, inverted PN
  localparam logic [2:0] KO = 3'd7;  // other K (K23.7)

  // {kind, err, dv, comma, cnt[1:0]}
  localparam int NV = 33;
  localparam logic [7:0] VEC [NV] = '{
    {KN, 3'b000, 2'd0}, {KN, 3'b000, 2'd0}, {KS, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KV, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0}, {KG, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0}, {KI, 3'b100, 2'd0}, {KD, 3'b100, 2'd0},
    {KG, 3'b100, 2'd0},
    {KG, 3'b010, 2'd0}, {KI, 3'b011, 2'd0}, {KD, 3'b010, 2'd0},
    {KG, 3'b010, 2'd0}, {KL, 3'b110, 2'd1}, {KG, 3'b010, 2'd1},
    {KO, 3'b010, 2'd1}, {KG, 3'b010, 2'd1}, {KL, 3'b110, 2'd2},
    {KN, 3'b000, 2'd2}, {KS, 3'b100, 2'd2}, {KG, 3'b100, 2'd2}
  };

  // R3: bench model of the PRBS7 byte following state s
  function automatic logic [7:0] pnByte(input logic [6:0] s);
    logic [6:0] t;
    logic [7:0] b;
    t = s;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      b[i] = t[6] ^ t[5];
      t = {t[5:0], b[i]};
    end
    return b;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] kind);
    logic [7:0] b;
    rxAligned = (kind != KN);
    rxIsK = 1'b0;
    rxComma = 1'b0;
    case (kind)
      KN: rxData = 8'h33;
      KS: begin rxData = 8'h5A; bSt = 7'h5A; end
      KG: begin b = pnByte(bSt); rxData = b; bSt = b[6:0]; end
      KV: begin b = pnByte(bSt) ^ 8'h01; rxData = b; bSt = b[6:0]; end
      KL: begin b = pnByte(bSt); rxData = b ^ 8'h80; bSt = b[6:0]; end
      KI: begin rxIsK = 1'b1; rxComma = 1'b1; rxData = 8'hBC; end
      KD: rxData = pnByte(bSt) ^ 8'hFF;
      default: begin rxIsK = 1'b1; rxData = 8'hF7; end
    endcase
    @(negedge clk);  // R10: result visible after one edge
  endtask

  function automatic string reqOf(input logic [2:0] kind, input logic [2:0] st);
    if (kind == KN) return "R1";
    if (kind == KD) return "R7";
    if (kind == KV) return "R4";
    if (st[2:1] == 2'b10) return "R2";
    if (st == 3'b110) return "R6";
    return "R5";
  endfunction

  initial begin
    wait (cycles == 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset count", mismatchCnt, 16'h0);
    check("R1 reset status", {13'b0, statErr, statDv, statComma}, 16'h0);
    rstN = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] kd;
      logic [2:0] st;
      kd = VEC[v][7:5];
      st = VEC[v][4:2];
      send(kd);
      check($sformatf("%s/R10 row %0d status", reqOf(kd, st), v),
            {13'b0, statErr, statDv, statComma}, {13'b0, st});
      check($sformatf("R9 row %0d count", v), mismatchCnt, {14'b0, VEC[v][1:0]});
    end

    // R8: after a dropout, lock must be rebuilt: 7 more matches keep it unlocked
    for (int i = 0; i < 6; i++) send(KG);
    check("R8 relock pending", {13'b0, statErr, statDv, statComma}, 16'h4);
    send(KG);
    send(KG);
    check("R4 relock complete", {13'b0, statErr, statDv, statComma}, 16'h2);

    // R9: saturation of the counter
    for (int i = 0; i < 65540; i++) send(KL);
    check("R9 saturated count", mismatchCnt, 16'hFFFF);
    check("R6 mismatch status at saturation", {13'b0, statErr, statDv, statComma}, 16'h6);
    send(KG);
    check("R9 held at max", mismatchCnt, 16'hFFFF);

    // R9: reset clears the counter
    rstN = 1'b0;
    @(negedge clk);
    check("R9 reset clears count", mismatchCnt, 16'h0);
    check("R1 reset clears status", {13'b0, statErr, statDv, statComma}, 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule